// File: doc/BRIEF.md
# General-purpose I/O port controller

This block controls a port of up to 32 general-purpose pins through a word-addressed register interface. Software drives the output levels with a plain output register or with write-one-to-set and write-one-to-clear aliases, so a single pin can change without a read-modify-write. The direction register has the same set and clear aliases. Every pin also has a configuration word that holds its direction, pull request, drive strength, input-disconnect bit and level-sense selection.

Pin levels pass through a two-flop synchroniser. The input register, the pull and drive requests, and the detect logic all work from the synchronised value. A pin with a nonzero sense field raises its own detect term when it sees the chosen level: 2 or 1 for high, 3 for low. The single `detect` output is either the OR of those terms or the OR of a sticky latch register, which software clears by writing ones. The bus read is combinational on the address, and a write takes effect on the clock edge where `bus_sel` and `bus_we` are both high. The two low address bits are ignored. An asynchronous active-low reset is released through an internal two-flop synchroniser.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads as follows: OUT, DIR, LATCH and DETECTMODE read 0, every configuration word reads 0x00000002, and `detect`, `pin_out`, `pin_oe`, `pin_pull_up` and `pin_pull_dn` are all 0.
- R2: A write to OUT (offset 0x504) loads the whole register. A write to OUTSET (0x508) sets exactly the bits written as 1, and a write to OUTCLR (0x50C) clears exactly the bits written as 1. `pin_out` always equals OUT.
- R3: DIR (0x514) is loaded by a write, DIRSET (0x518) sets the bits written as 1, and DIRCLR (0x51C) clears the bits written as 1. Zero bits leave DIR unchanged, and `pin_oe` equals DIR.
- R4: The configuration word for pin n is at 0x700 + 4*n. Its fields are: bit 0 direction, bit 1 input disconnect, bits 3:2 pull, bits 10:8 drive, bits 17:16 sense. All other bits read 0. Bit 0 and DIR bit n are one shared state bit.
- R5: A pull field of 3 asserts `pin_pull_up[n]`, and a pull field of 1 asserts `pin_pull_dn[n]`. `pin_drive[3n+2:3n]` carries the drive field.
- R6: IN (0x510) bit n shows the level of pin n two clock edges after the level changes, and reads 0 while the disconnect bit is set.
- R7: A sense field of 0 gives no detect term. A field of 2 detects a high level and 3 detects a low level. A disconnected pin gives no detect term.
- R8: A LATCH (0x520) bit is set on any edge where its pin's detect term is true, and it stays set until a 1 is written to it. If the term is still true on the clearing edge, the bit stays set.
- R9: With DETECTMODE (0x524) at 0, `detect` is the OR of the live detect terms. With DETECTMODE at 1, it is the OR of the LATCH bits, so it rises one edge after the term.
- R10: Offsets that are not mapped, including 0x600 and 0x780 (one word past pin 31), read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset from the port base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables |
| pin_pull_up | output | NPINS | Pull-up requests |
| pin_pull_dn | output | NPINS | Pull-down requests |
| pin_drive | output | 3*NPINS | Drive strength per pin |
| detect | output | 1 | Combined level-detect output |

## Verification
The register paths are tried with overlapping set and clear patterns. These patterns show whether the set, clear and plain-write aliases affect only the bits written as 1. Configuration writes with every bit high show that reserved bits are dropped and that the direction bit reaches DIR. Pin patterns that mix connected and disconnected pins, high and low sense, and transitions held for one edge and for two edges tell apart synchroniser latency, disconnect masking, the live combine and the latched combine. A clear written while a level is still present checks that the latch keeps the bit set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  // Byte offsets from the port base
  localparam logic [ADDR_W-1:0] OFS_OUT    = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_OUTSET = 12'h508;
  localparam logic [ADDR_W-1:0] OFS_OUTCLR = 12'h50C;
  localparam logic [ADDR_W-1:0] OFS_IN     = 12'h510;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h514;
  localparam logic [ADDR_W-1:0] OFS_DIRSET = 12'h518;
  localparam logic [ADDR_W-1:0] OFS_DIRCLR = 12'h51C;
  localparam logic [ADDR_W-1:0] OFS_LATCH  = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 12'h524;
  localparam logic [ADDR_W-1:0] OFS_CFG0   = 12'h700;

  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd3;
  localparam logic [1:0] SENSE_OFF = 2'd0;
  localparam logic [1:0] SENSE_LOW = 2'd3;

  // Per-pin configuration without direction (direction lives in DIR)
  typedef struct packed {
    logic [1:0] sense;
    logic [2:0] drive;
    logic [1:0] pull;
    logic       disc;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{sense: 2'd0, drive: 3'd0, pull: 2'd0, disc: 1'b1};

  function automatic logic [DATA_W-1:0] cfg_word(input pin_cfg_t c, input logic dir);
    return {14'd0, c.sense, 5'd0, c.drive, 4'd0, c.pull, c.disc, dir};
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] s1_q;
  logic [WIDTH-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

  // Edge counter since reset, so the two-deep look-back never reaches into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  a_r6_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      wr_en,
  input  logic [DATA_W-1:0]     wdata,
  output pin_cfg_t [NPINS-1:0]  cfg_q
);

  pin_cfg_t wr_val;

  always_comb begin
    wr_val.sense = wdata[17:16];
    wr_val.drive = wdata[10:8];
    wr_val.pull  = wdata[3:2];
    wr_val.disc  = wdata[1];
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q[g] <= CFG_RESET;
      else if (wr_en[g]) cfg_q[g] <= wr_val;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:18], wdata[15:11], wdata[7:4], wdata[0]};

  a_r4_single_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  a_r4_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     sync_in,
  input  pin_cfg_t [NPINS-1:0] cfg,
  input  logic                 clr_we,
  input  logic [NPINS-1:0]     clr_mask,
  input  logic                 latched_mode,
  output logic [NPINS-1:0]     in_val,
  output logic [NPINS-1:0]     latch_q,
  output logic                 detect
);

  logic [NPINS-1:0] det;
  logic [NPINS-1:0] clr_eff;
  logic [NPINS-1:0] latch_d;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic level_hit;
    assign level_hit = (cfg[g].sense == SENSE_LOW) ? ~sync_in[g] : sync_in[g];
    assign in_val[g] = sync_in[g] & ~cfg[g].disc;
    assign det[g]    = (cfg[g].sense != SENSE_OFF) & ~cfg[g].disc & level_hit;
  end

  // Next state: clear by write-one, a present detect term wins over the clear
  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    latch_d = (latch_q & ~clr_eff) | det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign detect = latched_mode ? (|latch_q) : (|det);

  a_r8_term_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(det) & ~latch_q) == '0));

  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(clr_eff) & ~$past(det)) == '0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q) & ~$past(clr_eff) & ~latch_q) == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_pull_up,
  output logic [NPINS-1:0]   pin_pull_dn,
  output logic [3*NPINS-1:0] pin_drive,
  output logic               detect
);

  localparam int unsigned IDX_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int unsigned WADDR_W = ADDR_W - 2;
  localparam logic [WADDR_W-1:0] CFG_WBASE = OFS_CFG0[ADDR_W-1:2];

  // ---------------- reset release synchroniser ----------------
  logic rst_s1_q, rst_s2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  // ---------------- address decode ----------------
  logic [WADDR_W-1:0] waddr;
  logic [WADDR_W-1:0] cfg_rel;
  logic [IDX_W-1:0]   cfg_idx;
  logic wr, rd;
  logic hit_out, hit_outset, hit_outclr, hit_in, hit_dir, hit_dirset, hit_dirclr;
  logic hit_latch, hit_mode, hit_cfg, hit_any;

  always_comb begin
    waddr      = bus_addr[ADDR_W-1:2];
    wr         = bus_sel & bus_we;
    rd         = bus_sel & ~bus_we;
    hit_out    = (waddr == OFS_OUT[ADDR_W-1:2]);
    hit_outset = (waddr == OFS_OUTSET[ADDR_W-1:2]);
    hit_outclr = (waddr == OFS_OUTCLR[ADDR_W-1:2]);
    hit_in     = (waddr == OFS_IN[ADDR_W-1:2]);
    hit_dir    = (waddr == OFS_DIR[ADDR_W-1:2]);
    hit_dirset = (waddr == OFS_DIRSET[ADDR_W-1:2]);
    hit_dirclr = (waddr == OFS_DIRCLR[ADDR_W-1:2]);
    hit_latch  = (waddr == OFS_LATCH[ADDR_W-1:2]);
    hit_mode   = (waddr == OFS_MODE[ADDR_W-1:2]);
    cfg_rel    = waddr - CFG_WBASE;
    cfg_idx    = cfg_rel[IDX_W-1:0];
    hit_cfg    = (waddr >= CFG_WBASE) && (cfg_rel < WADDR_W'(NPINS));
    hit_any    = hit_out | hit_outset | hit_outclr | hit_in | hit_dir | hit_dirset |
                 hit_dirclr | hit_latch | hit_mode | hit_cfg;
  end

  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] cfg_wr_en;
  assign wmask = bus_wdata[NPINS-1:0];

  always_comb begin
    cfg_wr_en = '0;
    if (wr && hit_cfg) cfg_wr_en[cfg_idx] = 1'b1;
  end

  // ---------------- output, direction and mode registers ----------------
  logic [NPINS-1:0] out_q, out_d;
  logic [NPINS-1:0] dir_q, dir_d;
  logic             mode_q, mode_d;
  logic             out_en, dir_en, mode_en;

  always_comb begin
    out_d   = out_q;
    out_en  = wr & (hit_out | hit_outset | hit_outclr);
    if (hit_out)    out_d = wmask;
    if (hit_outset) out_d = out_q | wmask;
    if (hit_outclr) out_d = out_q & ~wmask;

    dir_d   = dir_q;
    dir_en  = wr & (hit_dir | hit_dirset | hit_dirclr | hit_cfg);
    if (hit_dir)    dir_d = wmask;
    if (hit_dirset) dir_d = dir_q | wmask;
    if (hit_dirclr) dir_d = dir_q & ~wmask;
    if (hit_cfg)    dir_d[cfg_idx] = bus_wdata[0];

    mode_d  = bus_wdata[0];
    mode_en = wr & hit_mode;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (out_en)  out_q  <= out_d;
      if (dir_en)  dir_q  <= dir_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  // ---------------- sub-blocks ----------------
  pin_cfg_t [NPINS-1:0] cfg_q;
  logic [NPINS-1:0]     sync_in;
  logic [NPINS-1:0]     in_val;
  logic [NPINS-1:0]     latch_q;

  gpio_pin_cfg #(.NPINS(NPINS)) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (cfg_wr_en),
    .wdata (bus_wdata),
    .cfg_q (cfg_q)
  );

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_in),
    .q     (sync_in)
  );

  gpio_sense #(.NPINS(NPINS)) u_sense (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sync_in      (sync_in),
    .cfg          (cfg_q),
    .clr_we       (wr & hit_latch),
    .clr_mask     (wmask),
    .latched_mode (mode_q),
    .in_val       (in_val),
    .latch_q      (latch_q),
    .detect       (detect)
  );

  // ---------------- read mux ----------------
  function automatic logic [31:0] zext(input logic [NPINS-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_out)   bus_rdata = zext(out_q);
      if (hit_in)    bus_rdata = zext(in_val);
      if (hit_dir)   bus_rdata = zext(dir_q);
      if (hit_latch) bus_rdata = zext(latch_q);
      if (hit_mode)  bus_rdata = {31'd0, mode_q};
      if (hit_cfg)   bus_rdata = cfg_word(cfg_q[cfg_idx], dir_q[cfg_idx]);
    end
  end

  // ---------------- pin requests ----------------
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_req
    assign pin_pull_up[g]     = (cfg_q[g].pull == PULL_UP);
    assign pin_pull_dn[g]     = (cfg_q[g].pull == PULL_DOWN);
    assign pin_drive[3*g +: 3] = cfg_q[g].drive;
  end

  logic unused_addr;
  assign unused_addr = ^{bus_addr[1:0], bus_wdata};

  // ---------------- assertions ----------------
  a_r2_outset_bits: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr && hit_outset) |=> ((out_q & $past(wmask)) == $past(wmask)));

  a_r2_outclr_bits: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr && hit_outclr) |=> ((out_q & $past(wmask)) == '0));

  a_r3_dirset_bits: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr && hit_dirset) |=> ((dir_q & $past(wmask)) == $past(wmask)));

  a_r3_dirclr_bits: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr && hit_dirclr) |=> ((dir_q & $past(wmask)) == '0));

  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr && !hit_any) |=> ($stable(out_q) && $stable(dir_q) && $stable(mode_q) && $stable(cfg_q)));

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  localparam int NP = 32;

  logic          clk;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_we;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] pin_pull_up;
  logic [NP-1:0] pin_pull_dn;
  logic [3*NP-1:0] pin_drive;
  logic          detect;

  int checks;
  int errors;

  gpio_port #(.NPINS(NP)) u_gpio_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pin_pull_up (pin_pull_up),
    .pin_pull_dn (pin_pull_dn),
    .pin_drive   (pin_drive),
    .detect      (detect)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bench-side map
  localparam logic [11:0] A_OUT = 12'h504, A_OSET = 12'h508, A_OCLR = 12'h50C;
  localparam logic [11:0] A_IN = 12'h510, A_DIR = 12'h514, A_DSET = 12'h518, A_DCLR = 12'h51C;
  localparam logic [11:0] A_LAT = 12'h520, A_MODE = 12'h524;

  function automatic logic [11:0] a_cfg(input int n);
    return 12'h700 + 12'(4 * n);
  endfunction

  // {req[3:0], write, addr[11:0], data[31:0], expected[31:0]}
  localparam int NV = 24;
  localparam logic [80:0] VEC [0:NV-1] = '{
    {4'd2,  1'b1, 12'h504, 32'h0000_00F0, 32'h0},            // R2 plain write
    {4'd2,  1'b0, 12'h504, 32'h0,         32'h0000_00F0},
    {4'd2,  1'b1, 12'h508, 32'h0000_0F0F, 32'h0},            // R2 set alias
    {4'd2,  1'b0, 12'h504, 32'h0,         32'h0000_0FFF},
    {4'd2,  1'b1, 12'h50C, 32'h0000_00FF, 32'h0},            // R2 clear alias
    {4'd2,  1'b0, 12'h504, 32'h0,         32'h0000_0F00},
    {4'd3,  1'b1, 12'h518, 32'h8000_0001, 32'h0},            // R3 set alias
    {4'd3,  1'b0, 12'h514, 32'h0,         32'h8000_0001},
    {4'd3,  1'b1, 12'h51C, 32'h0000_0001, 32'h0},            // R3 clear alias
    {4'd3,  1'b0, 12'h514, 32'h0,         32'h8000_0000},
    {4'd4,  1'b1, 12'h714, 32'h0003_070D, 32'h0},            // R4 pin 5 word
    {4'd4,  1'b0, 12'h714, 32'h0,         32'h0003_070D},
    {4'd4,  1'b0, 12'h514, 32'h0,         32'h8000_0020},
    {4'd4,  1'b1, 12'h718, 32'hFFFF_FFFF, 32'h0},            // R4 reserved bits dropped
    {4'd4,  1'b0, 12'h718, 32'h0,         32'h0003_070F},
    {4'd4,  1'b0, 12'h514, 32'h0,         32'h8000_0060},
    {4'd10, 1'b1, 12'h600, 32'hFFFF_FFFF, 32'h0},            // R10 unmapped
    {4'd10, 1'b0, 12'h600, 32'h0,         32'h0},
    {4'd10, 1'b0, 12'h504, 32'h0,         32'h0000_0F00},
    {4'd10, 1'b0, 12'h514, 32'h0,         32'h8000_0060},
    {4'd10, 1'b1, 12'h780, 32'hFFFF_FFFF, 32'h0},            // R10 past last pin
    {4'd10, 1'b0, 12'h780, 32'h0,         32'h0},
    {4'd3,  1'b1, 12'h51C, 32'h0000_0000, 32'h0},            // R3 zero clear mask
    {4'd3,  1'b0, 12'h514, 32'h0,         32'h8000_0060}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd10:   return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the next falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string what);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(96'(bus_rdata), 96'(exp), what);
    bus_sel = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  bit done;

  initial begin
    done = 1'b0;
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    edges(5);
    rst_n = 1'b1;
    edges(4);

    // R1 reset state
    rd(A_OUT,  32'h0, "R1 OUT");
    rd(A_DIR,  32'h0, "R1 DIR");
    rd(A_LAT,  32'h0, "R1 LATCH");
    rd(A_MODE, 32'h0, "R1 DETECTMODE");
    rd(A_IN,   32'h0, "R1 IN");
    rd(a_cfg(0),  32'h2, "R1 cfg pin 0");
    rd(a_cfg(31), 32'h2, "R1 cfg pin 31");
    chk(96'(detect), 96'd0, "R1 detect");
    chk(96'(pin_out), 96'd0, "R1 pin_out");
    chk(96'(pin_oe), 96'd0, "R1 pin_oe");
    chk(96'({pin_pull_up, pin_pull_dn}), 96'd0, "R1 pulls");
    edges(1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], VEC[i][31:0], $sformatf("%s table vector %0d", req_name(VEC[i][80:77]), i));
        edges(1);
      end
    end

    // R2 R3 pin outputs follow registers
    chk(96'(pin_out), 96'h0000_0F00, "R2 pin_out");
    chk(96'(pin_oe),  96'h8000_0060, "R3 pin_oe");
    // R5 pulls and drive (pins 5 and 6 have pull 3, drive 7)
    chk(96'(pin_pull_up), 96'h60, "R5 pull up");
    chk(96'(pin_pull_dn), 96'h0,  "R5 pull down idle");
    chk(pin_drive, 96'h3F << 15, "R5 drive");
    wr(a_cfg(7), 32'h0000_0004);
    chk(96'(pin_pull_dn), 96'h80, "R5 pull down pin 7");

    // R7 low sense on pin 5 (input low) detects; pin 6 low sense but disconnected
    chk(96'(detect), 96'd1, "R7 R9 direct detect low level");
    rd(A_LAT, 32'h0000_0020, "R7 R8 latch pin 5 only");
    edges(1);

    // R6 input synchroniser and disconnect masking
    wr(a_cfg(0), 32'h0); wr(a_cfg(1), 32'h0); wr(a_cfg(2), 32'h0); wr(a_cfg(3), 32'h0);
    pin_in = 32'h0000_006F;
    rd(A_IN, 32'h0, "R6 IN before any edge");
    edges(1);
    rd(A_IN, 32'h0, "R6 IN after one edge");
    edges(1);
    rd(A_IN, 32'h0000_002F, "R6 IN after two edges, pin 6 masked");
    chk(96'(detect), 96'd0, "R7 low sense released");
    rd(A_LAT, 32'h0000_0020, "R8 latch sticky");
    edges(1);

    // R8 write one clears
    wr(A_LAT, 32'h0000_0020);
    rd(A_LAT, 32'h0, "R8 cleared");
    edges(1);
    wr(A_MODE, 32'h1);
    rd(A_MODE, 32'h1, "R9 mode readback");
    chk(96'(detect), 96'd0, "R9 latched mode empty");
    edges(1);

    // R7 high sense on pin 2 (input high); R9 latched detect lags one edge
    wr(a_cfg(2), 32'h0002_0000);
    chk(96'(detect), 96'd0, "R9 latched detect not yet set");
    edges(1);
    chk(96'(detect), 96'd1, "R7 R9 latched high-level detect");
    rd(A_LAT, 32'h0000_0004, "R7 latch pin 2");
    edges(1);
    wr(A_LAT, 32'h0000_0004);
    rd(A_LAT, 32'h0000_0004, "R8 set wins over clear");
    edges(1);
    pin_in = 32'h0000_006B;
    edges(3);
    chk(96'(detect), 96'd1, "R9 latched detect holds after level gone");
    wr(A_MODE, 32'h0);
    chk(96'(detect), 96'd0, "R9 direct mode no live term");
    wr(A_MODE, 32'h1);
    wr(A_LAT, 32'h0000_0004);
    rd(A_LAT, 32'h0, "R8 cleared after level gone");
    chk(96'(detect), 96'd0, "R9 latched mode cleared");
    edges(1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule